// File: doc/BRIEF.md
# DDR Write Command Timing Enforcer

This block sits in a memory controller between a request queue and the command bus. It accepts write, read and precharge requests, in order, and places them on a one-command-per-clock bus. For each write it produces a data-strobe enable window and a data-mask signal for the write data path. It keeps the timing that must follow a write burst: the write-to-read gap, the write-recovery gap before a precharge of the same bank, and the row-precharge period before any further command to a bank that was precharged.

The write-to-read and write-recovery gaps count from the last data cycle of the burst, not from the write command. A read or precharge request can carry an interrupt flag. If it does, and the write burst it targets still has data to come, the block masks all remaining data of that burst from the next cycle on. It then treats the last unmasked data cycle as the end of the burst and issues the command once the gap from that cycle is met. Without the flag, the command waits for the whole burst plus the gap. A write may follow a write on any clock, and the number of cycles between the two write commands sets how many data pairs of the first burst are kept.

Top module: `ddr_write_timer`

## Requirements
- R1: Operation codes on `req_op` and `cmd_op` are 01 write, 10 read, 11 precharge and 00 no command. An accepted request appears on `cmd_valid`/`cmd_op`/`cmd_bank`/`cmd_col` in the cycle after the clock edge that accepted it, and it stays there for exactly one cycle.
- R2: `dqs_en` is high for BURST_LEN/2 cycles, starting one cycle after the write command cycle. A write issued G cycles after a previous write (G below BURST_LEN/2) keeps G data cycles of the earlier burst, and the strobe stays continuous.
- R3: A read without the interrupt flag appears no sooner than T_WTR+1 cycles after the last data cycle of the current burst. When held from the cycle after a write, it appears exactly BURST_LEN/2+T_WTR+1 cycles after that write command.
- R4: A precharge without the interrupt flag appears no sooner than T_WR+1 cycles after the last data cycle written to its bank. After a full burst it issues at the same point an auto-precharge would take effect: BURST_LEN/2+T_WR+1 cycles after the write command. A precharge to a bank with no recent write issues at once.
- R5: An interrupting read, or an interrupting precharge to the bank of the current burst, raises `dm` (high means masked) on every remaining data cycle of that burst from the cycle after the first edge at which it is presented. The command then waits T_WTR (read) or T_WR (precharge) cycles after the last unmasked data cycle. An interrupting precharge to any other bank masks nothing.
- R6: After a precharge to a bank, no command to that bank appears until T_RP cycles after the precharge command cycle. Other banks are not delayed.
- R7: `req_ready` is low while timing blocks the request at the head of the queue. A request is issued only on an edge where `req_valid` and `req_ready` are both high, and requests issue in arrival order. The number of stalled cycles equals the wait implied by R3 to R6.
- R8: After reset, `cmd_valid`, `dqs_en` and `dm` are low and `req_ready` is high.
- R9: A request with code 00 is accepted at once and produces no command and no strobe.
- R10: An interrupting request that arrives after the burst data has ended masks nothing and issues as a non-interrupting request would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can issue on this edge |
| req_op | input | 2 | Request operation code |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_col | input | COL_W | Start column |
| req_trunc | input | 1 | Request may interrupt the current write burst |
| cmd_valid | output | 1 | Command on the bus this cycle |
| cmd_op | output | 2 | Command operation code |
| cmd_bank | output | $clog2(NUM_BANKS) | Command bank |
| cmd_col | output | COL_W | Command column |
| dqs_en | output | 1 | Write strobe enable, one cycle per data pair |
| dm | output | 1 | Data mask for the current data pair |

## Verification
The bench places a second request at several distances behind a write or a precharge. It measures the command-to-command distance, the strobe cycles, the masked cycles and the stalled cycles. An interrupting read that arrives halfway through a burst must mask only the last pair. A design that masked from the burst start would lose good data, and one that issued at once would break the write-to-read gap. An interrupting request that arrives after the data has ended must mask nothing. An interrupting precharge to a different bank must neither mask nor wait. Back-to-back writes must keep exactly the pairs set by their spacing, and a precharge must hold off only its own bank for the row-precharge period; an off-by-one count in any of these shifts the measured distance.

// File: rtl/ddr_wtim_pkg.sv
package ddr_wtim_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_WR  = 2'b01,
        CMD_RD  = 2'b10,
        CMD_PRE = 2'b11
    } cmd_op_e;
endpackage

// File: rtl/ddr_wtim_burst.sv
// Tracks the data window of the most recent write burst and drives strobe/mask.
module ddr_wtim_burst #(
    parameter int BURST_CYC = 2,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              cut_go,
    output logic              dqs_en,
    output logic              dm,
    output logic              data_ahead,
    output logic              cut_done,
    output logic [BANK_W-1:0] burst_bank
);
    localparam int LW = $clog2(BURST_CYC + 2);

    typedef struct packed {
        logic [LW-1:0]     left;
        logic              dqs;
        logic              dm;
        logic              cut;
        logic [BANK_W-1:0] bank;
    } st_t;

    st_t st_d, st_q;
    logic [LW-1:0] next_left;
    logic          ahead;

    always_comb begin
        next_left = (st_q.left != '0) ? st_q.left - 1'b1 : '0;
        ahead     = (next_left != '0) && (next_left <= LW'(BURST_CYC));
        st_d      = st_q;
        // the data cycle after this edge still belongs to the older burst
        st_d.dqs  = ahead;
        st_d.dm   = ahead && (st_q.cut || cut_go);
        st_d.left = wr_go ? LW'(BURST_CYC + 1) : next_left;
        st_d.cut  = wr_go ? 1'b0 : (cut_go ? 1'b1 : st_q.cut);
        st_d.bank = wr_go ? wr_bank : st_q.bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dqs_en     = st_q.dqs;
    assign dm         = st_q.dm;
    assign data_ahead = ahead;
    assign cut_done   = st_q.cut;
    assign burst_bank = st_q.bank;
endmodule

// File: rtl/ddr_wtim_bank.sv
// Per-bank write-recovery and row-precharge countdowns.
module ddr_wtim_bank #(
    parameter int CW      = 4,
    parameter int WR_LOAD = 4,
    parameter int WR_CUT  = 1,
    parameter int RP_LOAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic pre_go,
    input  logic cut_go,
    output logic wr_clear,
    output logic rp_clear
);
    typedef struct packed {
        logic [CW-1:0] wr;
        logic [CW-1:0] rp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_go)                st_d.wr = CW'(WR_LOAD);
        else if (cut_go)          st_d.wr = CW'(WR_CUT);
        else if (st_q.wr != '0)   st_d.wr = st_q.wr - 1'b1;
        if (pre_go)               st_d.rp = CW'(RP_LOAD);
        else if (st_q.rp != '0)   st_d.rp = st_q.rp - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_clear = (st_q.wr == '0);
    assign rp_clear = (st_q.rp == '0);
endmodule

// File: rtl/ddr_write_timer.sv
module ddr_write_timer #(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int T_WTR     = 1,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [COL_W-1:0]             req_col,
    input  logic                         req_trunc,
    output logic                         cmd_valid,
    output logic [1:0]                   cmd_op,
    output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    output logic [COL_W-1:0]             cmd_col,
    output logic                         dqs_en,
    output logic                         dm
);
    import ddr_wtim_pkg::*;

    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int CW        = $clog2(BURST_CYC + T_WTR + T_WR + T_RP + 2);

    typedef struct packed {
        logic [CW-1:0]     wtr;
        logic              cmd_valid;
        logic [1:0]        cmd_op;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } st_t;

    st_t st_d, st_q;

    logic                 is_wr, is_rd, is_pre, fire, cut_hit, rdy;
    logic                 data_ahead, cut_done;
    logic [BANK_W-1:0]    burst_bank;
    logic [NUM_BANKS-1:0] wr_clear, rp_clear;

    always_comb begin
        is_wr   = (req_op == CMD_WR);
        is_rd   = (req_op == CMD_RD);
        is_pre  = (req_op == CMD_PRE);
        cut_hit = req_valid && req_trunc && data_ahead && !cut_done &&
                  (is_rd || (is_pre && req_bank == burst_bank));
        case (req_op)
            CMD_WR:  rdy = rp_clear[req_bank];
            CMD_RD:  rdy = rp_clear[req_bank] && (st_q.wtr == '0) && !cut_hit;
            CMD_PRE: rdy = rp_clear[req_bank] && wr_clear[req_bank] && !cut_hit;
            default: rdy = 1'b1;
        endcase
        fire = req_valid && rdy;

        st_d = st_q;
        if (fire && is_wr)              st_d.wtr = CW'(BURST_CYC + T_WTR);
        else if (cut_hit && is_rd)      st_d.wtr = CW'(T_WTR - 1);
        else if (st_q.wtr != '0)        st_d.wtr = st_q.wtr - 1'b1;
        st_d.cmd_valid = fire && (req_op != CMD_NOP);
        st_d.cmd_op    = st_d.cmd_valid ? req_op : CMD_NOP;
        if (fire) begin
            st_d.bank = req_bank;
            st_d.col  = req_col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ddr_wtim_burst #(
        .BURST_CYC (BURST_CYC),
        .BANK_W    (BANK_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_go      (fire && is_wr),
        .wr_bank    (req_bank),
        .cut_go     (cut_hit),
        .dqs_en     (dqs_en),
        .dm         (dm),
        .data_ahead (data_ahead),
        .cut_done   (cut_done),
        .burst_bank (burst_bank)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        ddr_wtim_bank #(
            .CW      (CW),
            .WR_LOAD (BURST_CYC + T_WR),
            .WR_CUT  (T_WR - 1),
            .RP_LOAD (T_RP - 1)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_go    (fire && is_wr && req_bank == BANK_W'(gi)),
            .pre_go   (fire && is_pre && req_bank == BANK_W'(gi)),
            .cut_go   (cut_hit && is_pre && req_bank == BANK_W'(gi)),
            .wr_clear (wr_clear[gi]),
            .rp_clear (rp_clear[gi])
        );
    end

    assign req_ready = rdy;
    assign cmd_valid = st_q.cmd_valid;
    assign cmd_op    = st_q.cmd_op;
    assign cmd_bank  = st_q.bank;
    assign cmd_col   = st_q.col;
endmodule

// File: rtl/ddr_write_timer_chk.sv
module ddr_write_timer_chk #(
    parameter int NUM_BANKS = 4,
    parameter int T_WTR     = 1,
    parameter int T_WR      = 2,
    parameter int T_RP      = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         cmd_valid,
    input logic [1:0]                   cmd_op,
    input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input logic                         dqs_en,
    input logic                         dm
);
    import ddr_wtim_pkg::*;
    localparam int BANK_W = $clog2(NUM_BANKS);

    logic [7:0]        since_data;
    logic [7:0]        since_bdata [NUM_BANKS];
    logic [7:0]        since_pre   [NUM_BANKS];
    logic [BANK_W-1:0] owner_bank;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_data <= 8'hFF;
            owner_bank <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                since_bdata[b] <= 8'hFF;
                since_pre[b]   <= 8'hFF;
            end
        end else begin
            since_data <= (dqs_en && !dm) ? 8'd1 :
                          (since_data == 8'hFF ? since_data : since_data + 8'd1);
            for (int b = 0; b < NUM_BANKS; b++) begin
                since_bdata[b] <= (dqs_en && !dm && owner_bank == BANK_W'(b)) ? 8'd1 :
                                  (since_bdata[b] == 8'hFF ? since_bdata[b] : since_bdata[b] + 8'd1);
                since_pre[b]   <= (cmd_valid && cmd_op == CMD_PRE && cmd_bank == BANK_W'(b)) ? 8'd1 :
                                  (since_pre[b] == 8'hFF ? since_pre[b] : since_pre[b] + 8'd1);
            end
            if (cmd_valid && cmd_op == CMD_WR) owner_bank <= cmd_bank;
        end
    end

    // R1
    cmd_from_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(req_valid && req_ready));
    // R2
    strobe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_WR) |=> dqs_en);
    // R3
    wtr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_RD) |-> (since_data > 8'(T_WTR)));
    // R4
    wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_PRE) |-> (since_bdata[cmd_bank] > 8'(T_WR)));
    // R5
    mask_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm |-> dqs_en);
    // R6
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (since_pre[cmd_bank] >= 8'(T_RP)));
    // R7
    stall_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !cmd_valid);
endmodule

bind ddr_write_timer ddr_write_timer_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_WTR     (T_WTR),
    .T_WR      (T_WR),
    .T_RP      (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .dqs_en    (dqs_en),
    .dm        (dm)
);

// File: tb/ddr_write_timer_tb.sv
module ddr_write_timer_tb;
    import ddr_wtim_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [1:0] req_bank = 2'd0;
    logic [9:0] req_col = '0;
    logic       req_trunc = 1'b0;
    logic       req_ready, cmd_valid, dqs_en, dm;
    logic [1:0] cmd_op, cmd_bank;
    logic [9:0] cmd_col;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_write_timer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_col(req_col), .req_trunc(req_trunc),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .dqs_en(dqs_en), .dm(dm)
    );

    typedef struct packed {
        logic [1:0] op1;
        logic [1:0] op2;
        logic       trunc;
        logic       same;
        logic [3:0] pd;
        logic [3:0] dly;
        logic [3:0] dqs;
        logic [3:0] msk;
        logic [3:0] rq;
    } vec_t;

    // first op, second op, interrupt, same bank, presentation delay,
    // expected command distance, strobe cycles, masked cycles, requirement
    localparam vec_t VEC [13] = '{
        '{2'b01, 2'b10, 1'b0, 1'b1, 4'd1, 4'd4, 4'd2, 4'd0, 4'd3},  // R3 burst end + gap
        '{2'b01, 2'b11, 1'b0, 1'b1, 4'd1, 4'd5, 4'd2, 4'd0, 4'd4},  // R4 auto-precharge point
        '{2'b01, 2'b10, 1'b1, 1'b1, 4'd1, 4'd2, 4'd2, 4'd2, 4'd5},  // R5 whole burst masked
        '{2'b01, 2'b11, 1'b1, 1'b1, 4'd1, 4'd3, 4'd2, 4'd2, 4'd5},  // R5 precharge cut
        '{2'b01, 2'b11, 1'b0, 1'b0, 4'd1, 4'd1, 4'd2, 4'd0, 4'd4},  // R4 idle bank
        '{2'b01, 2'b01, 1'b0, 1'b0, 4'd1, 4'd1, 4'd3, 4'd0, 4'd2},  // R2 one pair kept
        '{2'b01, 2'b10, 1'b1, 1'b1, 4'd2, 4'd3, 4'd2, 4'd1, 4'd5},  // R5 last pair masked
        '{2'b01, 2'b10, 1'b1, 1'b1, 4'd4, 4'd4, 4'd2, 4'd0, 4'd10}, // R10 late interrupt
        '{2'b01, 2'b01, 1'b0, 1'b1, 4'd2, 4'd2, 4'd4, 4'd0, 4'd2},  // R2 seamless pair
        '{2'b01, 2'b11, 1'b1, 1'b0, 4'd1, 4'd1, 4'd2, 4'd0, 4'd5},  // R5 other bank no cut
        '{2'b11, 2'b01, 1'b0, 1'b1, 4'd1, 4'd3, 4'd2, 4'd0, 4'd6},  // R6 write after precharge
        '{2'b11, 2'b01, 1'b0, 1'b0, 4'd1, 4'd1, 4'd2, 4'd0, 4'd6},  // R6 other bank free
        '{2'b11, 2'b10, 1'b0, 1'b1, 4'd1, 4'd3, 4'd0, 4'd0, 4'd6}   // R6 read after precharge
    };

    task automatic check(input int rq, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL R%0d %s got %0d exp %0d", rq, what, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] bank, input logic tr);
        req_valid = 1'b1; req_op = op; req_bank = bank; req_trunc = tr;
        req_col = 10'(bank) + 10'h20;
    endtask

    task automatic run_row(input int idx, input vec_t v);
        int n_cmd = 0, c0 = 0, c1 = 0, n_dqs = 0, n_dm = 0, stalls = 0;
        int stage = 0, gap = 0;
        bit live = 1'b0, rdy_prev = 1'b0;
        for (int t = 0; t < 24; t++) begin
            @(negedge clk);
            if (cmd_valid) begin
                if (n_cmd == 0) c0 = cyc; else c1 = cyc;
                n_cmd++;
            end
            n_dqs += int'(dqs_en);
            n_dm  += int'(dm);
            if (live && rdy_prev) begin
                live = 1'b0; req_valid = 1'b0; req_trunc = 1'b0;
                if (stage == 0) begin stage = 1; gap = int'(v.pd) - 1; end
                else stage = 2;
            end
            if (!live) begin
                if (stage == 0 && t == 0) begin
                    drive(v.op1, 2'd0, 1'b0); live = 1'b1;
                end else if (stage == 1) begin
                    if (gap == 0) begin
                        drive(v.op2, v.same ? 2'd0 : 2'd2, v.trunc); live = 1'b1;
                    end else gap--;
                end
            end
            #1;
            rdy_prev = req_ready;
            if (live && !req_ready && stage == 1) stalls++;
        end
        check(int'(v.rq), $sformatf("row %0d command count", idx), n_cmd, 2);
        check(int'(v.rq), $sformatf("row %0d distance", idx), c1 - c0, int'(v.dly));
        check(int'(v.rq), $sformatf("row %0d strobe cycles", idx), n_dqs, int'(v.dqs));
        check(int'(v.rq), $sformatf("row %0d masked cycles", idx), n_dm, int'(v.msk));
        // R7: stalled cycles equal the timing wait
        check(7, $sformatf("row %0d stalls", idx), stalls, int'(v.dly) - int'(v.pd));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R8: reset state
        check(8, "ready after reset", int'(req_ready), 1);
        check(8, "cmd_valid after reset", int'(cmd_valid), 0);
        check(8, "dqs_en after reset", int'(dqs_en), 0);
        check(8, "dm after reset", int'(dm), 0);

        // R1: command fields one cycle after acceptance
        @(negedge clk);
        drive(CMD_WR, 2'd3, 1'b0); req_col = 10'h155; #1;
        check(1, "write ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(1, "cmd_valid", int'(cmd_valid), 1);
        check(1, "cmd_op", int'(cmd_op), 1);
        check(1, "cmd_bank", int'(cmd_bank), 3);
        check(1, "cmd_col", int'(cmd_col), 10'h155);
        @(negedge clk);
        check(1, "single cycle command", int'(cmd_valid), 0);
        repeat (10) @(negedge clk);

        // R9: no-op request consumed silently
        drive(CMD_NOP, 2'd1, 1'b0); #1;
        check(9, "no-op ready", int'(req_ready), 1);
        begin
            int seen = 0;
            @(negedge clk); req_valid = 1'b0;
            for (int t = 0; t < 6; t++) begin
                seen += int'(cmd_valid) + int'(dqs_en);
                @(negedge clk);
            end
            check(9, "no-op activity", seen, 0);
        end
        repeat (6) @(negedge clk);

        for (int i = 0; i < 13; i++) run_row(i, VEC[i]);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog expired got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule